// File: doc/BRIEF.md
# Dual Buffer Page Program Controller

This block sits behind a serial flash front-end. It owns two byte buffers, each one page long, and a small array of pages. The front-end decodes each command header, hands over the opcode, page number and starting byte address, and then streams the data bytes in. The controller fills the buffers and moves whole pages between a buffer and the array. It runs every page operation as a self-timed sequence. Cell timing is replaced by cycle counters.

Page operations are armed by their command but start only when chip select returns high. While one buffer is being programmed into the array, the other buffer can still take new data, so the two buffers can be used in turn. A write-protect input blocks any programming of the lowest page range. A ready/busy bit is always readable in the status byte.

The array holds `PAGES` pages. The 13-bit page number selects page number modulo `PAGES`, so the bench can use a small array. The protection limit is still compared against the full 13-bit page number.

Top module: `dbuf_prog_ctrl`

## Requirements
- R1: After reset, busy is 0 and the status byte reads 0x80.
- R2: Opcode 0x84 writes buffer 0 and opcode 0x87 writes buffer 1. Data bytes go in starting at the command's byte address, and the address steps by one after each byte. The byte after byte 527 goes to byte 0 of the same buffer. A start address of 528 or more is reduced by 528.
- R3: Opcodes 0x83 (from buffer 0) and 0x86 (from buffer 1) erase the page and then program the buffer into it, so the page ends equal to the buffer. Busy rises on the clock that first sees chip select high. It stays high for exactly T_ERASE + 528 + T_PROG cycles.
- R4: Opcodes 0x88 (buffer 0) and 0x89 (buffer 1) program without erase. Each page byte becomes old byte AND buffer byte. Busy lasts 528 + T_PROG cycles.
- R5: Opcodes 0x82 (buffer 0) and 0x85 (buffer 1) first load data into the buffer as in R2. On chip select rising they then perform the R3 erase-and-program of that buffer into the given page.
- R6: Opcodes 0x53 (to buffer 0) and 0x55 (to buffer 1) copy the page into the buffer. Busy lasts 528 + T_XFR cycles.
- R7: Status bit 7 is 1 when ready and 0 when busy, and bits 6..0 read 0. The status byte is valid on every cycle, busy or not.
- R8: A program or transfer command issued while busy is ignored. It does not start an operation when chip select rises, and the page it names is unchanged.
- R9: While busy, plain buffer writes to the buffer not used by the running operation are stored. Writes to the buffer in use are dropped.
- R10: If write-protect is low when chip select rises, a program aimed at a page number below 256 is refused. Busy stays 0 and the page is unchanged. Pages 256 and above, and transfers, still proceed.
- R11: An armed page operation does not start while chip select stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low; its rising edge starts armed operations |
| cmd_valid | input | 1 | Decoded command header present this cycle |
| cmd_op | input | 8 | Command opcode |
| cmd_page | input | PAGE_W | Page number of the command |
| cmd_addr | input | ADDR_W | Starting byte address in the buffer |
| wr_valid | input | 1 | Data byte present this cycle |
| wr_data | input | 8 | Data byte for the open buffer write |
| wp_n | input | 1 | Write-protect, low protects pages below 256 |
| rd_from_page | input | 1 | Read port source: 1 array, 0 buffer |
| rd_buf | input | 1 | Read port buffer select |
| rd_page | input | PAGE_W | Read port page number |
| rd_addr | input | ADDR_W | Read port byte address |
| rd_data | output | 8 | Read port byte (combinational) |
| busy | output | 1 | Page operation in progress |
| status | output | 8 | Status byte, bit 7 = ready |

## Verification
A wrong phase counter or a wrong sequencing state shows at the ports straight away. The reference model is compared with busy and the status byte on every clock, so a busy interval that starts one cycle late or ends one cycle early shows as a mismatch at that exact cycle. A wrong copy index, a wrong buffer select or a dropped ping-pong write stays hidden until the operation ends. It then shows as a wrong byte on the read port, at the first read-back after busy falls. Refused and ignored commands are caught in two ways: busy staying low when it should, and the named page reading back its old contents.

// File: rtl/dbuf_prog_ctrl.sv
module dbuf_prog_ctrl #(
  parameter int PAGES      = 4,
  parameter int PAGE_BYTES = 528,
  parameter int PAGE_W     = 13,
  parameter int ADDR_W     = 10,
  parameter int PROT_LIMIT = 256,
  parameter int T_ERASE    = 24,
  parameter int T_PROG     = 40,
  parameter int T_XFR      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_op,
  input  logic [PAGE_W-1:0] cmd_page,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              wr_valid,
  input  logic [7:0]        wr_data,
  input  logic              wp_n,
  input  logic              rd_from_page,
  input  logic              rd_buf,
  input  logic [PAGE_W-1:0] rd_page,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic [7:0]        status
);
  localparam int MA_W  = $clog2(PAGES * PAGE_BYTES);
  localparam int BB_W  = $clog2(2 * PAGE_BYTES);
  localparam int CNT_W = 16;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(PAGE_BYTES - 1);

  typedef enum logic [1:0] {S_IDLE, S_ERASE, S_COPY, S_HOLD} st_t;
  typedef enum logic [1:0] {K_ERPG, K_PROG, K_XFR} kind_t;

  logic [7:0] arr  [PAGES*PAGE_BYTES];
  logic [7:0] bufm [2*PAGE_BYTES];

  st_t               st;
  kind_t             act_kind, pend_kind, dec_kind;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] idx, wr_ptr;
  logic [PAGE_W-1:0] act_page, pend_page;
  logic              act_buf, pend_buf, pend, wr_open, wr_buf, cs_q;
  logic              dec_write, dec_buf, dec_has_op;

  function automatic logic [MA_W-1:0] aidx(logic [PAGE_W-1:0] p, logic [ADDR_W-1:0] a);
    return MA_W'(p % PAGE_W'(PAGES)) * MA_W'(PAGE_BYTES) + MA_W'(a);
  endfunction

  function automatic logic [BB_W-1:0] bidx(logic b, logic [ADDR_W-1:0] a);
    return BB_W'(b) * BB_W'(PAGE_BYTES) + BB_W'(a);
  endfunction

  always_comb begin
    dec_write  = cmd_op inside {8'h84, 8'h87, 8'h82, 8'h85};
    dec_buf    = cmd_op inside {8'h87, 8'h85, 8'h86, 8'h89, 8'h55};
    dec_has_op = 1'b1;
    dec_kind   = K_ERPG;
    case (cmd_op)
      8'h82, 8'h85, 8'h83, 8'h86: dec_kind = K_ERPG;
      8'h88, 8'h89:               dec_kind = K_PROG;
      8'h53, 8'h55:               dec_kind = K_XFR;
      default:                    dec_has_op = 1'b0;
    endcase
  end

  assign busy    = (st != S_IDLE);
  assign status  = {~busy, 7'd0};

  wire cs_rise = cs_n & ~cs_q;
  wire cmd_ok  = cmd_valid & ~cs_n;
  wire prot    = ~wp_n & (pend_page < PAGE_W'(PROT_LIMIT)) & (pend_kind != K_XFR);
  wire start   = cs_rise & pend & ~prot;
  wire wr_step = wr_open & wr_valid & ~cs_n;
  wire wr_go   = wr_step & ~(busy & (wr_buf == act_buf));

  assign rd_data = rd_from_page ? arr[aidx(rd_page, rd_addr)] : bufm[bidx(rd_buf, rd_addr)];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;  cnt <= '0;  idx <= '0;  cs_q <= 1'b1;
      act_kind <= K_ERPG;  act_buf <= 1'b0;  act_page <= '0;
      pend <= 1'b0;  pend_kind <= K_ERPG;  pend_buf <= 1'b0;  pend_page <= '0;
      wr_open <= 1'b0;  wr_buf <= 1'b0;  wr_ptr <= '0;
    end else begin
      cs_q <= cs_n;
      if (wr_step) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + ADDR_W'(1);
      if (cmd_ok) begin
        wr_open   <= dec_write & ~(dec_has_op & busy);
        wr_buf    <= dec_buf;
        wr_ptr    <= (cmd_addr >= ADDR_W'(PAGE_BYTES)) ? cmd_addr - ADDR_W'(PAGE_BYTES) : cmd_addr;
        pend      <= dec_has_op & ~busy;
        pend_kind <= dec_kind;
        pend_buf  <= dec_buf;
        pend_page <= cmd_page;
      end else if (cs_rise) begin
        wr_open <= 1'b0;
        pend    <= 1'b0;
      end
      case (st)
        S_IDLE: if (start) begin
          act_kind <= pend_kind;  act_buf <= pend_buf;  act_page <= pend_page;
          idx <= '0;
          if (pend_kind == K_ERPG) begin
            st  <= S_ERASE;
            cnt <= CNT_W'(T_ERASE - 1);
          end else st <= S_COPY;
        end
        S_ERASE: if (cnt == '0) st <= S_COPY; else cnt <= cnt - CNT_W'(1);
        S_COPY: begin
          idx <= idx + ADDR_W'(1);
          if (idx == LAST) begin
            st  <= S_HOLD;
            cnt <= (act_kind == K_XFR) ? CNT_W'(T_XFR - 1) : CNT_W'(T_PROG - 1);
          end
        end
        default: if (cnt == '0) st <= S_IDLE; else cnt <= cnt - CNT_W'(1);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_COPY && act_kind != K_XFR)
      arr[aidx(act_page, idx)] <= (act_kind == K_ERPG) ? bufm[bidx(act_buf, idx)]
                                  : (arr[aidx(act_page, idx)] & bufm[bidx(act_buf, idx)]);
  end

  always_ff @(posedge clk) begin
    if (st == S_COPY && act_kind == K_XFR)
      bufm[bidx(act_buf, idx)] <= arr[aidx(act_page, idx)];
    if (wr_go)
      bufm[bidx(wr_buf, wr_ptr)] <= wr_data;
  end
endmodule

module dbuf_prog_ctrl_chk #(
  parameter int PAGE_W     = 13,
  parameter int ADDR_W     = 10,
  parameter int PAGE_BYTES = 528,
  parameter int PROT_LIMIT = 256,
  parameter int T_ERASE    = 24,
  parameter int T_PROG     = 40,
  parameter int T_XFR      = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              wp_n,
  input logic              busy,
  input logic [PAGE_W-1:0] act_page,
  input logic [1:0]        act_kind,
  input logic [ADDR_W-1:0] wr_ptr
);
  logic [15:0] run;
  always_ff @(posedge clk)
    if (!rst_n || !busy) run <= '0;
    else run <= run + 16'd1;

  // R11
  r11_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_n) && !$past(cs_n, 2));

  // R10
  r10_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) && !$past(wp_n) |-> (act_page >= PAGE_W'(PROT_LIMIT)) || (act_kind == 2'd2));

  // R8
  r8_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(act_page) && $stable(act_kind));

  // R2
  r2_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr < ADDR_W'(PAGE_BYTES));

  // R3
  r3_dur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run == 16'(T_ERASE + PAGE_BYTES + T_PROG)) ||
                    (run == 16'(PAGE_BYTES + T_PROG)) || (run == 16'(PAGE_BYTES + T_XFR)));
endmodule

bind dbuf_prog_ctrl dbuf_prog_ctrl_chk #(
  .PAGE_W(PAGE_W), .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .PROT_LIMIT(PROT_LIMIT),
  .T_ERASE(T_ERASE), .T_PROG(T_PROG), .T_XFR(T_XFR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .busy(busy),
  .act_page(act_page), .act_kind(act_kind), .wr_ptr(wr_ptr)
);

// File: tb/sim_dbuf_prog_ctrl.sv
module sim_dbuf_prog_ctrl;
  localparam int PG = 4, PB = 528, TE = 24, TP = 40, TX = 16;

  logic clk = 0, rst_n = 0, cs_n = 1, cmd_valid = 0, wr_valid = 0, wp_n = 1;
  logic rd_from_page = 0, rd_buf = 0;
  logic [7:0] cmd_op = 0, wr_data = 0;
  logic [12:0] cmd_page = 0, rd_page = 0;
  logic [9:0] cmd_addr = 0, rd_addr = 0;
  logic [7:0] rd_data, status;
  logic busy;

  always #5 clk = ~clk;

  dbuf_prog_ctrl #(.PAGES(PG), .PAGE_BYTES(PB), .T_ERASE(TE), .T_PROG(TP), .T_XFR(TX)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_page(cmd_page), .cmd_addr(cmd_addr), .wr_valid(wr_valid), .wr_data(wr_data),
    .wp_n(wp_n), .rd_from_page(rd_from_page), .rd_buf(rd_buf), .rd_page(rd_page),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .status(status));

  int n_cmp = 0, n_bad = 0;
  int mb [2][PB];
  int ma [PG][PB];
  int m_left, m_open, m_wbuf, m_ptr, m_pend, m_pkind, m_pbuf, m_ppage, m_abuf, m_csq;

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // reference model, updated on each rising edge from the inputs the design sees
  always @(posedge clk) begin : mdl
    int op, kd, pi;
    bit rise, bpre, iw, bsel;
    if (!rst_n) begin
      m_left = 0; m_open = 0; m_wbuf = 0; m_ptr = 0; m_pend = 0;
      m_pkind = 0; m_pbuf = 0; m_ppage = 0; m_abuf = 0; m_csq = 1;
    end else begin
      rise = cs_n && !m_csq;
      bpre = m_left > 0;
      if (m_open && wr_valid && !cs_n) begin
        if (!(bpre && m_wbuf == m_abuf)) mb[m_wbuf][m_ptr] = wr_data;
        m_ptr = (m_ptr == PB - 1) ? 0 : m_ptr + 1;
      end
      if (m_left > 0) m_left--;
      if (cmd_valid && !cs_n) begin
        op   = cmd_op;
        iw   = op inside {'h84, 'h87, 'h82, 'h85};
        bsel = op inside {'h87, 'h85, 'h86, 'h89, 'h55};
        kd   = (op inside {'h82, 'h85, 'h83, 'h86}) ? 0 :
               (op inside {'h88, 'h89}) ? 1 : (op inside {'h53, 'h55}) ? 2 : -1;
        m_open  = iw && !(kd >= 0 && bpre);
        m_wbuf  = bsel;
        m_ptr   = (cmd_addr >= PB) ? cmd_addr - PB : cmd_addr;
        m_pend  = (kd >= 0) && !bpre;
        m_pkind = kd;
        m_pbuf  = bsel;
        m_ppage = cmd_page;
      end else if (rise) begin
        if (m_pend && !(wp_n == 0 && m_ppage < 256 && m_pkind != 2)) begin
          pi = m_ppage % PG;
          for (int k = 0; k < PB; k++) begin
            if (m_pkind == 0)      ma[pi][k] = mb[m_pbuf][k];
            else if (m_pkind == 1) ma[pi][k] = ma[pi][k] & mb[m_pbuf][k];
            else                   mb[m_pbuf][k] = ma[pi][k];
          end
          m_left = (m_pkind == 0) ? TE + PB + TP : (m_pkind == 1) ? PB + TP : PB + TX;
          m_abuf = m_pbuf;
        end
        m_pend = 0;
        m_open = 0;
      end
      m_csq = cs_n;
    end
  end

  always @(negedge clk) if (rst_n) begin
    check("R3 busy vs model", busy, (m_left > 0) ? 1 : 0);
    check("R7 status vs model", status, (m_left > 0) ? 'h00 : 'h80);
  end

  task automatic open_cmd(int op, int page, int addr);
    @(negedge clk);
    cs_n = 0; cmd_valid = 1; cmd_op = 8'(op); cmd_page = 13'(page); cmd_addr = 10'(addr);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic send(int n, int seed, int mul);
    for (int i = 0; i < n; i++) begin
      wr_valid = 1; wr_data = 8'((i * mul + seed) & 255);
      @(negedge clk);
    end
    wr_valid = 0;
  endtask

  task automatic close_cs();
    cs_n = 1;
    @(negedge clk);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic rdx(string tag, bit pg, int b, int page, int addr, int exp);
    rd_from_page = pg; rd_buf = b; rd_page = 13'(page); rd_addr = 10'(addr);
    #1;
    check(tag, rd_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R3 watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset busy", busy, 0);
    check("R1 reset status", status, 'h80);

    // R2 fill both buffers
    open_cmd('h84, 0, 0); send(PB, 3, 7); close_cs();
    rdx("R2 buf0 byte 0", 0, 0, 0, 0, 3);
    rdx("R2 buf0 byte 527", 0, 0, 0, 527, (527 * 7 + 3) & 255);
    rdx("R2 buf0 byte 100", 0, 0, 0, 100, (100 * 7 + 3) & 255);
    open_cmd('h87, 0, 0); send(PB, 'h5A, 13); close_cs();
    // R2 wrap past byte 527
    open_cmd('h87, 0, 526); send(4, 'hC0, 1); close_cs();
    rdx("R2 wrap byte 527", 0, 1, 0, 527, 'hC1);
    rdx("R2 wrap byte 0", 0, 1, 0, 0, 'hC2);
    rdx("R2 wrap byte 1", 0, 1, 0, 1, 'hC3);
    rdx("R2 wrap byte 2 untouched", 0, 1, 0, 2, (2 * 13 + 'h5A) & 255);
    // R2 start address fold
    open_cmd('h87, 0, 1000); send(1, 'h11, 0); close_cs();
    rdx("R2 folded address 472", 0, 1, 0, 472, 'h11);

    // R11 no start while chip select low, then R3 erase-program
    open_cmd('h83, 2, 0);
    for (int i = 0; i < 5; i++) begin check("R11 busy while cs low", busy, 0); @(negedge clk); end
    close_cs();
    wait_idle(n);
    check("R3 erase-program busy length", n, TE + PB + TP);
    rdx("R3 page2 byte 0", 1, 0, 2, 0, 3);
    rdx("R3 page2 byte 300", 1, 0, 2, 300, (300 * 7 + 3) & 255);

    // R4 program without erase
    open_cmd('h89, 2, 0); close_cs();
    wait_idle(n);
    check("R4 no-erase busy length", n, PB + TP);
    rdx("R4 page2 byte 5 AND", 1, 0, 2, 5, ((5 * 7 + 3) & 255) & ((5 * 13 + 'h5A) & 255));
    rdx("R4 page2 byte 0 AND", 1, 0, 2, 0, 3 & 'hC2);
    rdx("R4 page2 byte 472", 1, 0, 2, 472, ((472 * 7 + 3) & 255) & 'h11);

    // R6 page to buffer transfer
    open_cmd('h53, 2, 0); close_cs();
    wait_idle(n);
    check("R6 transfer busy length", n, PB + TX);
    rdx("R6 buf0 byte 5", 0, 0, 0, 5, ((5 * 7 + 3) & 255) & ((5 * 13 + 'h5A) & 255));
    rdx("R6 buf0 byte 400", 0, 0, 0, 400, ma[2][400]);

    // R9 ping-pong writes and R8 ignored command while busy
    open_cmd('h86, 3, 0); close_cs();
    check("R9 busy started", busy, 1);
    open_cmd('h84, 0, 10); send(3, 'hA0, 1); close_cs();
    open_cmd('h87, 0, 10); send(3, 'hB0, 1); close_cs();
    open_cmd('h88, 2, 0); close_cs();
    wait_idle(n);
    for (int i = 0; i < 4; i++) begin check("R8 no later start", busy, 0); @(negedge clk); end
    rdx("R9 free buffer written", 0, 0, 0, 11, 'hA1);
    rdx("R9 busy buffer kept", 0, 1, 0, 10, (10 * 13 + 'h5A) & 255);
    rdx("R9 page3 from buffer1", 1, 0, 3, 10, (10 * 13 + 'h5A) & 255);
    rdx("R8 page2 unchanged", 1, 0, 2, 11, ((11 * 7 + 3) & 255) & ((11 * 13 + 'h5A) & 255));

    // R5 write then program in one command
    open_cmd('h82, 1, 20); send(8, 'h30, 2); close_cs();
    wait_idle(n);
    check("R5 busy length", n, TE + PB + TP);
    rdx("R5 page1 byte 20", 1, 0, 1, 20, 'h30);
    rdx("R5 page1 byte 27", 1, 0, 1, 27, 'h3E);
    rdx("R5 page1 byte 11", 1, 0, 1, 11, 'hA1);

    // R10 write protect
    wp_n = 0;
    open_cmd('h86, 1, 0); close_cs();
    for (int i = 0; i < 3; i++) begin check("R10 refused stays ready", busy, 0); @(negedge clk); end
    rdx("R10 page1 unchanged", 1, 0, 1, 20, 'h30);
    open_cmd('h86, 257, 0); close_cs();
    check("R10 page 257 accepted", busy, 1);
    wait_idle(n);
    rdx("R10 page 257 written", 1, 0, 1, 20, (20 * 13 + 'h5A) & 255);
    open_cmd('h55, 2, 0); close_cs();
    wait_idle(n);
    check("R10 transfer allowed length", n, PB + TX);
    rdx("R10 transfer result", 1, 0, 2, 0, ma[2][0]);
    rdx("R10 buf1 after transfer", 0, 1, 0, 0, 3 & 'hC2);
    wp_n = 1;

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule